// File: doc/BRIEF.md
# ECC Error Logging and Injection Registers

This block sits next to a SECDED-protected DRAM datapath and gives software a view of the errors that the decoder reports. For each of the two error classes, correctable and uncorrectable, it holds the address, the 8-bit syndrome and the 64-bit data word of the first error seen. While that first record is still pending, any further error of the same class only raises an overflow flag. Four status flags drive a level interrupt. Software clears them by writing ones to an acknowledge word.

An option word holds the ECC mode and a one-shot injection control. When injection is armed, the next write on the datapath leaves with its check bits XORed by a programmed 8-bit pattern. The arm bit then clears itself. Software reaches the registers through a simple synchronous port with word addresses, a window select and a registered read path.

Top module: `ecc_err_log`

## Requirements
- R1: After reset, the interrupt status word reads 0, `irq` is low, every capture word reads 0, and the option word reads the reset mode 1 in bits 1:0 with all other bits 0.
- R2: With logging enabled and no correctable error pending, a cycle with `err_ce` high sets status bit 3. It also captures `err_addr` at word 6, the syndrome in bits 15:8 of word 7, data bits 31:0 at word 8 and data bits 63:32 at word 9. All of these words are in window 0.
- R3: With logging enabled and no uncorrectable error pending, a cycle with `err_ue` high sets status bit 5. It also captures address, syndrome (bits 15:8) and data low/high at window-0 words 2, 3, 4 and 5.
- R4: An error of a class whose first-error bit (3 or 5) is still set after that cycle's acknowledge sets the class's double bit (4 or 6) and leaves the captured address, syndrome and data unchanged.
- R5: A write to window 1, word 1 clears every status bit 6:3 whose matching write-data bit is 1. An error arriving in the same cycle as an acknowledge of its first-error bit keeps that bit set and is captured as a new first error. The acknowledge word reads 0.
- R6: `irq` is high exactly when any of status bits 6:3 is set, and it falls only after an acknowledge.
- R7: While option bits 1:0 hold 0 or 2, errors set no status bit and change no capture word.
- R8: Option bit 8 arms injection and bits 23:16 hold the pattern. The next cycle with `wr_valid` high gives `chk_out = chk_in ^ pattern`, and bit 8 then clears. While bit 8 is 0, `chk_out` equals `chk_in`. A software write to the option word takes priority over the self-clear.
- R9: A read returns its data in `reg_rdata` one cycle after `reg_rd`. The value reflects the state before any write in the same cycle. Window 0 word 1, words 10 to 15, and window 1 words 2 to 15 read as 0. Writes to capture and status words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_win | input | 1 | Window select: 0 option and capture words, 1 status and acknowledge |
| reg_addr | input | 4 | Word address within the window |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Level interrupt, OR of status bits 6:3 |
| err_ce | input | 1 | Decoder reports a correctable error this cycle |
| err_ue | input | 1 | Decoder reports an uncorrectable error this cycle |
| err_addr | input | 32 | Address of the reported error |
| err_syn | input | 8 | Syndrome of the reported error |
| err_data | input | 64 | Data word of the reported error |
| wr_valid | input | 1 | A datapath write passes this cycle |
| chk_in | input | 8 | Check bits from the encoder |
| chk_out | output | 8 | Check bits sent to memory, pattern applied when armed |

## Verification
The assertions assume that the decoder's report inputs are defined whenever `err_ce` or `err_ue` is high, and that a software acknowledge and a new error of the same class may meet in one cycle. They do not assume that software always clears bits it has seen. The stimulus draws error strobes, acknowledge masks, option writes and datapath writes from a seeded generator, so all of these overlaps occur, including reports while logging is off. Every read address stays within the four address bits. Writes to capture words are mixed in on purpose.

// File: rtl/ecc_err_log.sv
module ecc_err_log #(
  parameter logic [1:0] RESET_MODE = 2'b01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_win,
  input  logic [3:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  input  logic        err_ce,
  input  logic        err_ue,
  input  logic [31:0] err_addr,
  input  logic [7:0]  err_syn,
  input  logic [63:0] err_data,
  input  logic        wr_valid,
  input  logic [7:0]  chk_in,
  output logic [7:0]  chk_out
);

  logic [1:0]  mode;
  logic        fwc;
  logic [7:0]  pat;
  logic [3:0]  st;
  logic [31:0] ce_a, ue_a;
  logic [7:0]  ce_s, ue_s;
  logic [63:0] ce_d, ue_d;
  logic [31:0] rd_mux;

  wire       en     = mode[0];
  wire       opt_wr = reg_wr & ~reg_win & (reg_addr == 4'd0);
  wire       ack_wr = reg_wr &  reg_win & (reg_addr == 4'd1);
  wire [3:0] ack    = ack_wr ? reg_wdata[6:3] : 4'b0;
  wire [3:0] kept   = st & ~ack;
  wire       ce_new = err_ce & en & ~kept[0];
  wire       ce_dbl = err_ce & en &  kept[0];
  wire       ue_new = err_ue & en & ~kept[2];
  wire       ue_dbl = err_ue & en &  kept[2];

  assign irq     = |st;
  assign chk_out = chk_in ^ (fwc ? pat : 8'h00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= RESET_MODE;
      fwc  <= 1'b0;
      pat  <= 8'h00;
    end else if (opt_wr) begin
      mode <= reg_wdata[1:0];
      fwc  <= reg_wdata[8];
      pat  <= reg_wdata[23:16];
    end else if (wr_valid) begin
      fwc  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= 4'b0;
    else        st <= kept | {ue_dbl, ue_new, ce_dbl, ce_new};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_a <= '0; ce_s <= '0; ce_d <= '0;
    end else if (ce_new) begin
      ce_a <= err_addr; ce_s <= err_syn; ce_d <= err_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ue_a <= '0; ue_s <= '0; ue_d <= '0;
    end else if (ue_new) begin
      ue_a <= err_addr; ue_s <= err_syn; ue_d <= err_data;
    end
  end

  always_comb begin
    rd_mux = 32'h0;
    if (reg_win) begin
      if (reg_addr == 4'd0) rd_mux = {25'b0, st, 3'b0};
    end else begin
      case (reg_addr)
        4'd0: rd_mux = {8'b0, pat, 7'b0, fwc, 6'b0, mode};
        4'd2: rd_mux = ue_a;
        4'd3: rd_mux = {16'b0, ue_s, 8'b0};
        4'd4: rd_mux = ue_d[31:0];
        4'd5: rd_mux = ue_d[63:32];
        4'd6: rd_mux = ce_a;
        4'd7: rd_mux = {16'b0, ce_s, 8'b0};
        4'd8: rd_mux = ce_d[31:0];
        4'd9: rd_mux = ce_d[63:32];
        default: rd_mux = 32'h0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= 32'h0;
    else if (reg_rd) reg_rdata <= rd_mux;
    else             reg_rdata <= 32'h0;
  end

endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_win,
  input logic [3:0]  reg_addr,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic        irq,
  input logic        err_ce,
  input logic        wr_valid,
  input logic [7:0]  chk_in,
  input logic [7:0]  chk_out,
  input logic [3:0]  st,
  input logic [1:0]  mode,
  input logic        fwc,
  input logic [31:0] ce_a
);
  wire ack_wr = reg_wr &  reg_win & (reg_addr == 4'd1);
  wire opt_wr = reg_wr & ~reg_win & (reg_addr == 4'd0);

  AST_ACK_CLEARS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && reg_wdata[3] && !err_ce) |=> !st[0]); // R5
  AST_DOUBLE_NEEDS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st[1]) |-> st[0]); // R4
  AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st[0] && !(ack_wr && reg_wdata[3])) |=> $stable(ce_a)); // R4
  AST_OFF_NO_LOG: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[0] |=> ((st & ~$past(st)) == 4'b0)); // R7
  AST_INJECT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && fwc && !opt_wr) |=> !fwc); // R8
  AST_NO_FLIP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fwc |-> (chk_out == chk_in)); // R8
  AST_IRQ_FALL_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(ack_wr)); // R6
endmodule

bind ecc_err_log ecc_err_log_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_win(reg_win), .reg_addr(reg_addr),
  .reg_wr(reg_wr), .reg_wdata(reg_wdata), .irq(irq), .err_ce(err_ce),
  .wr_valid(wr_valid), .chk_in(chk_in), .chk_out(chk_out),
  .st(st), .mode(mode), .fwc(fwc), .ce_a(ce_a)
);

// File: tb/ecc_err_log_test.sv
module ecc_err_log_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_win = 0, reg_wr = 0, reg_rd = 0, err_ce = 0, err_ue = 0, wr_valid = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, err_addr = 0, reg_rdata;
  logic [7:0] err_syn = 0, chk_in = 0, chk_out;
  logic [63:0] err_data = 0;
  logic irq;

  ecc_err_log uut (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [1:0] m_mode; logic m_fwc; logic [7:0] m_pat; logic [3:0] m_st;
  logic [31:0] m_cea, m_uea; logic [7:0] m_ces, m_ues; logic [63:0] m_ced, m_ued;

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(logic w, logic [3:0] a);
    if (w) return (a == 4'd0) ? {25'b0, m_st, 3'b0} : 32'h0;
    case (a)
      4'd0: return {8'b0, m_pat, 7'b0, m_fwc, 6'b0, m_mode};
      4'd2: return m_uea;
      4'd3: return {16'b0, m_ues, 8'b0};
      4'd4: return m_ued[31:0];
      4'd5: return m_ued[63:32];
      4'd6: return m_cea;
      4'd7: return {16'b0, m_ces, 8'b0};
      4'd8: return m_ced[31:0];
      4'd9: return m_ced[63:32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_reset();
    m_mode = 2'b01; m_fwc = 0; m_pat = 0; m_st = 0;
    m_cea = 0; m_uea = 0; m_ces = 0; m_ues = 0; m_ced = 0; m_ued = 0;
  endtask

  task automatic tick(string req);
    logic [31:0] exp_rd;
    logic [3:0] ack, kept;
    logic en;
    bit rd;
    #1;
    if (wr_valid) check(chk_out == (chk_in ^ (m_fwc ? m_pat : 8'h0)), {req, " R8 chk_out"},
                        chk_out, chk_in ^ (m_fwc ? m_pat : 8'h0));
    rd = reg_rd;
    exp_rd = model_read(reg_win, reg_addr);
    en = m_mode[0];
    ack = (reg_wr && reg_win && reg_addr == 4'd1) ? reg_wdata[6:3] : 4'b0;
    kept = m_st & ~ack;
    if (err_ce && en) begin
      if (!kept[0]) begin kept[0] = 1; m_cea = err_addr; m_ces = err_syn; m_ced = err_data; end
      else kept[1] = 1;
    end
    if (err_ue && en) begin
      if (!kept[2]) begin kept[2] = 1; m_uea = err_addr; m_ues = err_syn; m_ued = err_data; end
      else kept[3] = 1;
    end
    m_st = kept;
    if (reg_wr && !reg_win && reg_addr == 4'd0) begin
      m_mode = reg_wdata[1:0]; m_fwc = reg_wdata[8]; m_pat = reg_wdata[23:16];
    end else if (wr_valid) m_fwc = 0;
    @(negedge clk);
    if (rd) check(reg_rdata == exp_rd, {req, " R9 read"}, reg_rdata, exp_rd);
    check(irq == (|m_st), {req, " R6 irq"}, irq, |m_st);
    reg_wr = 0; reg_rd = 0; err_ce = 0; err_ue = 0; wr_valid = 0;
  endtask

  task automatic rd(logic w, logic [3:0] a, string req);
    reg_win = w; reg_addr = a; reg_rd = 1; tick(req);
  endtask

  task automatic wr(logic w, logic [3:0] a, logic [31:0] d, string req);
    reg_win = w; reg_addr = a; reg_wdata = d; reg_wr = 1; tick(req);
  endtask

  task automatic err(bit ce, bit ue, logic [31:0] a, logic [7:0] s, logic [63:0] d);
    err_ce = ce; err_ue = ue; err_addr = a; err_syn = s; err_data = d;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    done = 1;
  end

  initial begin
    void'($urandom(32'd4021));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    for (int a = 0; a < 16; a++) rd(1'b0, a[3:0], "R1");
    rd(1'b1, 4'd0, "R1");
    // R2 first correctable
    err(1, 0, 32'h1234_5678, 8'h5A, 64'hDEAD_BEEF_0BAD_F00D); tick("R2");
    for (int a = 6; a < 10; a++) rd(1'b0, a[3:0], "R2");
    rd(1'b1, 4'd0, "R2");
    // R4 second correctable keeps capture
    err(1, 0, 32'hAAAA_0000, 8'h11, 64'h1); tick("R4");
    rd(1'b0, 4'd6, "R4"); rd(1'b1, 4'd0, "R4");
    // R3 uncorrectable
    err(0, 1, 32'h0000_0F00, 8'hC3, 64'h0123_4567_89AB_CDEF); tick("R3");
    for (int a = 2; a < 6; a++) rd(1'b0, a[3:0], "R3");
    err(0, 1, 32'h5, 8'h1, 64'h2); tick("R4");
    rd(1'b1, 4'd0, "R4"); rd(1'b0, 4'd2, "R4");
    // R5 partial ack, ack readback, ack plus same-cycle error
    wr(1'b1, 4'd1, 32'h0000_0018, "R5"); rd(1'b1, 4'd0, "R5"); rd(1'b1, 4'd1, "R5");
    err(0, 1, 32'h7777_7777, 8'h99, 64'h3);
    reg_win = 1; reg_addr = 1; reg_wdata = 32'h20; reg_wr = 1; tick("R5");
    rd(1'b1, 4'd0, "R5"); rd(1'b0, 4'd2, "R5");
    wr(1'b1, 4'd1, 32'h78, "R6"); rd(1'b1, 4'd0, "R6");
    // R7 disabled modes
    wr(1'b0, 4'd0, 32'h2, "R7"); err(1, 1, 32'h1, 8'h1, 64'h1); tick("R7");
    wr(1'b0, 4'd0, 32'h0, "R7"); err(1, 1, 32'h2, 8'h2, 64'h2); tick("R7");
    rd(1'b1, 4'd0, "R7"); rd(1'b0, 4'd6, "R7");
    // R8 injection once, then self-clear
    wr(1'b0, 4'd0, 32'h00A5_0103, "R8");
    chk_in = 8'h0F; wr_valid = 1; tick("R8");
    chk_in = 8'h0F; wr_valid = 1; tick("R8");
    rd(1'b0, 4'd0, "R8");
    wr(1'b0, 4'd0, 32'h00FF_0001, "R8");
    chk_in = 8'h3C; wr_valid = 1; tick("R8");
    // R9 unmapped and read-only words
    wr(1'b0, 4'd6, 32'hFFFF_FFFF, "R9"); rd(1'b0, 4'd6, "R9");
    rd(1'b0, 4'd1, "R9"); rd(1'b0, 4'd12, "R9"); rd(1'b1, 4'd9, "R9");
    // random mix
    for (int i = 0; i < 6000 && !done; i++) begin
      err_ce = ($urandom % 6) == 0; err_ue = ($urandom % 8) == 0;
      err_addr = $urandom; err_syn = 8'($urandom); err_data = {$urandom, $urandom};
      wr_valid = ($urandom % 4) == 0; chk_in = 8'($urandom);
      reg_rd = 1; reg_win = 1'($urandom); reg_addr = 4'($urandom);
      if (($urandom % 5) == 0) begin
        reg_wr = 1;
        if (($urandom % 3) == 0) begin
          reg_wdata = $urandom;
          if (($urandom % 4) != 0) reg_wdata[0] = 1'b1;
        end else reg_wdata = $urandom & 32'h78;
      end
      tick("R4/R5 random");
    end
    done = 1;
  end

  initial begin
    wait (done);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule